// File: doc/BRIEF.md
# Half-duplex transmit/receive mode supervisor

This block owns the direction decision of a half-duplex line modem. A single active-low direction request asks for transmit; when it is high the modem listens. The block turns that request into two mutually exclusive enables, one that gates the transmit path and one that gates the receive path. The analog carrier path, filters and modulator sit outside and only obey these enables.

A transmit session is guarded by a watchdog. A request that stays low too long is overridden and the modem falls back to receive. After such a forced return the modem stays in receive until the request line has been released high for a minimum time and then pulled low again. Two test inputs adjust the watchdog: one swaps the long limit for a much shorter one, the other suspends the forced return entirely. The active-low reset doubles as power-down and silences both enables.

The controller has three states. RECEIVE is the idle state. START_TX moves it from RECEIVE to TRANSMIT when the request is low. TRANSMIT has two exits: STOP_TX back to RECEIVE when the request goes high, and TIMEOUT to LOCKED when the watchdog expires. LOCKED is receive with transmit barred. REARM moves it from LOCKED to RECEIVE once the request has been high long enough. All three inputs pass through two-flop synchronizers before the state machine sees them.

Top module: `hdx_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `tx_en` and `rx_en` are both 0 at once. All state is cleared. After release the block starts in RECEIVE, with the request seen as high.
- R2: In RECEIVE, a low `dir_req_n` gives `tx_en`=1 and `rx_en`=0 after the third rising clock edge that follows the input change. This is far inside the 1 ms carrier start budget.
- R3: In TRANSMIT, a high `dir_req_n` gives `tx_en`=0 and `rx_en`=1 after the third rising edge that follows the change.
- R4: Out of reset, `tx_en` and `rx_en` are never 1 together.
- R5: With both test inputs low, TRANSMIT lasts exactly `LONG_CYC` clock cycles while the request stays low (default 33,177,600, which is 3 s at 11.0592 MHz). The block then moves to LOCKED, with `tx_en`=0 and `rx_en`=1.
- R6: While `tst_short` is high, the transmit limit is `SHORT_CYC` cycles (default 16,384, which is about 1.48 ms).
- R7: While `tst_hold` is high, there is no forced return, and a low request keeps `tx_en`=1 without limit.
- R8: In LOCKED, a low request does not restart transmit. The pin must be high for at least `REARM_CYC` consecutive cycles (default 23, which is 2 µs or more). A shorter high pulse leaves the block in LOCKED. After a long enough pulse, a falling request enters TRANSMIT after the third rising edge.
- R9: The watchdog count is cleared whenever the request is high. Every new transmit session therefore gets the full limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 11.0592 MHz |
| rst_n | input | 1 | Active-low asynchronous reset and power-down |
| dir_req_n | input | 1 | Direction request, 0 = transmit, 1 = receive |
| tst_short | input | 1 | Test: use the short transmit limit |
| tst_hold | input | 1 | Test: suppress the forced return to receive |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |

## Verification
A request edge reaches the enables after exactly three rising edges: two synchronizer stages and the registered output that is computed from the next state. The bench changes inputs 1 ns after a rising edge and samples 1 ns after the edge on which a result is due. It also samples one edge earlier to show the change has not yet happened. A forced return is checked on the exact edge at `LONG_CYC` or `SHORT_CYC` cycles after TRANSMIT began, with the edge before it also checked. Re-arming is checked with pulses of exactly `REARM_CYC` and `REARM_CYC`-1 cycles. After the qualifying pulse, the request falls and TRANSMIT is expected on the third edge. Test inputs are held for three edges before any stimulus that depends on them.

// File: rtl/hdx_mode_pkg.sv
package hdx_mode_pkg;

    typedef enum logic [1:0] {
        ST_RX   = 2'd0,
        ST_TX   = 2'd1,
        ST_LOCK = 2'd2
    } hdx_state_t;

endpackage

// File: rtl/hdx_sync.sv
module hdx_sync #(
    parameter int unsigned  W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic stage1;
            logic stage2;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage1 <= RST_VAL[b];
                    stage2 <= RST_VAL[b];
                end else begin
                    stage1 <= d[b];
                    stage2 <= stage1;
                end
            end
            assign q[b] = stage2;
        end
    endgenerate

endmodule

// File: rtl/hdx_tx_timer.sv
module hdx_tx_timer #(
    parameter int unsigned LONG_CYC  = 33177600,
    parameter int unsigned SHORT_CYC = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic req_hi,
    input  logic short_sel,
    input  logic hold,
    output logic expire
);

    localparam int unsigned CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit  = short_sel ? SHORT_LAST : LONG_LAST;
    assign expire = run && !req_hi && !hold && (cnt >= limit);

    // Counts cycles spent in transmit; cleared by a high request (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || req_hi) begin
            cnt <= '0;
        end else if (cnt < LONG_LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LONG_LAST);

    p_cnt_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && req_hi) |=> (cnt == '0));

endmodule

// File: rtl/hdx_rearm_gate.sv
module hdx_rearm_gate #(
    parameter int unsigned REARM_CYC = 23
) (
    input  logic clk,
    input  logic rst_n,
    input  logic locked,
    input  logic req_hi,
    output logic ready
);

    localparam int unsigned HW = $clog2(REARM_CYC + 1);
    localparam logic [HW-1:0] HI_LAST = HW'(REARM_CYC - 1);

    logic [HW-1:0] hcnt;

    assign ready = locked && req_hi && (hcnt >= HI_LAST);

    // Counts consecutive high-request cycles while locked (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (!locked || !req_hi) begin
            hcnt <= '0;
        end else if (hcnt < HI_LAST) begin
            hcnt <= hcnt + 1'b1;
        end
    end

    p_ready_rising_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(req_hi));

endmodule

// File: rtl/hdx_mode_ctrl.sv
module hdx_mode_ctrl
    import hdx_mode_pkg::*;
#(
    parameter int unsigned LONG_CYC  = 33177600,
    parameter int unsigned SHORT_CYC = 16384,
    parameter int unsigned REARM_CYC = 23
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_req_n,
    input  logic tst_short,
    input  logic tst_hold,
    output logic tx_en,
    output logic rx_en
);

    localparam int unsigned NIN = 3;

    logic [NIN-1:0] raw_in;
    logic [NIN-1:0] syn_in;
    logic           req_hi;
    logic           short_s;
    logic           hold_s;
    logic           tmr_exp;
    logic           rearm_ok;

    hdx_state_t state;
    hdx_state_t nxt;

    assign raw_in  = {tst_hold, tst_short, dir_req_n};
    assign req_hi  = syn_in[0];
    assign short_s = syn_in[1];
    assign hold_s  = syn_in[2];

    hdx_sync #(
        .W       (NIN),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    hdx_tx_timer #(
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state == ST_TX),
        .req_hi    (req_hi),
        .short_sel (short_s),
        .hold      (hold_s),
        .expire    (tmr_exp)
    );

    hdx_rearm_gate #(
        .REARM_CYC (REARM_CYC)
    ) u_rearm (
        .clk    (clk),
        .rst_n  (rst_n),
        .locked (state == ST_LOCK),
        .req_hi (req_hi),
        .ready  (rearm_ok)
    );

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RX: begin
                if (!req_hi) nxt = ST_TX;          // START_TX
            end
            ST_TX: begin
                if (req_hi)       nxt = ST_RX;     // STOP_TX
                else if (tmr_exp) nxt = ST_LOCK;   // TIMEOUT
            end
            ST_LOCK: begin
                if (rearm_ok) nxt = ST_RX;         // REARM
            end
            default: nxt = ST_RX;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RX;
        else        state <= nxt;
    end

    // Registered enables, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else begin
            tx_en <= (nxt == ST_TX);
            rx_en <= (nxt != ST_TX);
        end
    end

    p_powerdown_r1: assert property (@(posedge clk)
        !rst_n |-> (!tx_en && !rx_en));

    p_start_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX && !req_hi) |=> tx_en);

    p_stop_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && req_hi) |=> (rx_en && !tx_en));

    p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en && rx_en));

    p_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && !req_hi && tmr_exp) |=> (state == ST_LOCK));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && !req_hi && hold_s) |=> (state == ST_TX));

    p_lock_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && !rearm_ok) |=> (state == ST_LOCK && !tx_en));

endmodule

// File: tb/hdx_mode_ctrl_tb_top.sv
module hdx_mode_ctrl_tb_top;

    localparam int LONG  = 300;
    localparam int SHORT = 40;
    localparam int REARM = 23;

    logic clk = 1'b0;
    logic rst_n;
    logic dir_req_n;
    logic tst_short;
    logic tst_hold;
    logic tx_en;
    logic rx_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    hdx_mode_ctrl #(
        .LONG_CYC  (LONG),
        .SHORT_CYC (SHORT),
        .REARM_CYC (REARM)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_req_n (dir_req_n),
        .tst_short (tst_short),
        .tst_hold  (tst_hold),
        .tx_en     (tx_en),
        .rx_en     (rx_en)
    );

    // {tx_en, rx_en} expectations
    localparam logic [1:0] E_OFF = 2'b00;
    localparam logic [1:0] E_RX  = 2'b01;
    localparam logic [1:0] E_TX  = 2'b10;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [1:0] exp);
        n_chk++;
        if ({tx_en, rx_en} !== exp) begin
            n_bad++;
            $display("FAIL %s: {tx_en,rx_en} actual %b expected %b at %0t",
                     req, {tx_en, rx_en}, exp, $time);
        end
    endtask

    // R2: enter transmit, check the exact third edge
    task automatic t_enter_tx(input string req);
        dir_req_n = 1'b0;
        tick(2); chk(req, E_RX);
        tick(1); chk(req, E_TX);
    endtask

    // R3: leave transmit normally
    task automatic t_leave_tx(input string req);
        dir_req_n = 1'b1;
        tick(2); chk(req, E_TX);
        tick(1); chk(req, E_RX);
    endtask

    // R8: release the request for n cycles from LOCKED
    task automatic t_pulse(input int n);
        dir_req_n = 1'b1;
        tick(n);
        dir_req_n = 1'b0;
    endtask

    task automatic t_reset_state;
        #1;
        chk("R1", E_OFF);
        tick(2); chk("R1", E_OFF);
        rst_n = 1'b1;
        tick(1); chk("R1", E_RX);
    endtask

    task automatic t_basic;
        t_enter_tx("R2");
        tick(10); chk("R4", E_TX);
        t_leave_tx("R3");
    endtask

    task automatic t_timeout_rearm;
        t_enter_tx("R2");
        tick(LONG - 1); chk("R5", E_TX);
        tick(1);        chk("R5", E_RX);
        tick(40);       chk("R8", E_RX);
        t_pulse(REARM - 1);
        tick(40);       chk("R8", E_RX);
        t_pulse(REARM);
        tick(2); chk("R8", E_RX);
        tick(1); chk("R8", E_TX);
        t_leave_tx("R3");
    endtask

    task automatic t_clear;
        t_enter_tx("R9");
        tick(LONG / 2);
        t_leave_tx("R9");
        t_enter_tx("R9");
        tick(LONG - 1); chk("R9", E_TX);
        tick(1);        chk("R9", E_RX);
        t_pulse(REARM + 4);
        dir_req_n = 1'b1;
        tick(5); chk("R9", E_RX);
    endtask

    task automatic t_short;
        tst_short = 1'b1;
        tick(3);
        t_enter_tx("R6");
        tick(SHORT - 1); chk("R6", E_TX);
        tick(1);         chk("R6", E_RX);
        dir_req_n = 1'b1;
        tick(REARM + 4);
        tst_short = 1'b0;
        tick(3); chk("R6", E_RX);
    endtask

    task automatic t_hold;
        tst_hold = 1'b1;
        tick(3);
        t_enter_tx("R7");
        tick(LONG + 50); chk("R7", E_TX);
        t_leave_tx("R7");
        tst_hold = 1'b0;
        tick(3);
    endtask

    task automatic t_midreset;
        t_enter_tx("R1");
        rst_n = 1'b0;
        #1; chk("R1", E_OFF);
        tick(2); chk("R1", E_OFF);
        rst_n = 1'b1;
        tick(1); chk("R1", E_RX);
        tick(1); chk("R1", E_RX);
        tick(1); chk("R1", E_TX);
        t_leave_tx("R3");
    endtask

    initial begin
        rst_n     = 1'b1;
        dir_req_n = 1'b1;
        tst_short = 1'b0;
        tst_hold  = 1'b0;
        #1 rst_n  = 1'b0;
        t_reset_state();
        t_basic();
        t_timeout_rearm();
        t_clear();
        t_short();
        t_hold();
        t_midreset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule